// File: doc/BRIEF.md
# Descriptor Mailbox Register Block

This block sits between a host bus and a command engine. The host stages the address of a command descriptor, one byte at a time, in a small byte-wide register window. It then rings a doorbell bit in the control/status register (CSR). The block holds that entry in a one-deep slot and offers it to the engine over a valid/ready handshake. In the other direction, the engine pushes the addresses of finished descriptors into a completion FIFO. The block shows the oldest of them to the host through the same address registers, flagged by a remove-request bit. The host retires that entry by writing the bit back.

Several CSR bits act differently for reads and for writes. The add bit reads back as "add still pending". The busy bit reflects the engine on reads, and writes to it are dropped. The semaphore bit is test-and-set on reads and released by writing it. A soft reset flushes the slot, the completion FIFO, the outstanding count and the fatal-error state, then clears itself after a fixed number of cycles. A level interrupt reports a waiting completion.

Top module: `desc_mbox_regs`

## Requirements
- R1: Registers decode only at odd byte offsets: address bytes 0..3 (LSB first) at 1, 3, 5, 7; address modifier at 9; CSR at 0xB; fatal code at 0xD. Reads at even offsets return 0, and writes to them change nothing.
- R2: Writing CSR with bit 2 set copies the staged address and modifier into the slot. From the next cycle `sub_valid` is high with that entry, and CSR bit 2 reads 1 until the engine accepts it (`sub_valid && sub_ready`).
- R3: A write of CSR bit 2 while bit 2 reads 1 is ignored: the offered address and modifier stay unchanged, even if the staging registers were rewritten.
- R4: While the completion FIFO is not empty, CSR bit 1 reads 1 and offsets 1/3/5/7 return the bytes of the oldest finished address. When it is empty, they return the staged bytes.
- R5: Writing CSR bit 1 while it reads 1 retires the oldest completion, and the next one is shown. `cmp_ready` is low while the FIFO holds CMP_DEPTH entries.
- R6: CSR bit 7 reads the `eng_busy` input. Writing bit 7 changes no state.
- R7: The first `fatal_valid` sets CSR bit 6 and latches its code at offset 0xD (e.g. 0xF2). Later codes are ignored until a soft reset. Before any fatal error, offset 0xD reads 0.
- R8: Writing CSR bit 3 = 1 starts a soft reset. For RESET_CYCLES cycles, bit 3 reads 1, `eng_reset` is high, `cmp_ready` is low, and the slot, completion FIFO, outstanding count and fatal state are cleared. Bit 3 then clears itself, and writing it 0 does not cut the reset short.
- R9: CSR bit 5 is a plain read/write maintenance flag loaded on every CSR write. Bit 4 always reads 0.
- R10: CSR bit 0 is a test-and-set semaphore. A CSR read returns the current value and sets it, and a CSR write with bit 0 = 1 clears it.
- R11: At most MAX_OUT descriptors are outstanding (accepted but not yet retired). At that limit `sub_valid` stays low and CSR bit 2 stays 1 until a retire frees a slot.
- R12: With modifier 0x3D (24-bit mode), `sub_addr[31:24]` is forced to 0. With 0x0D or any other value, the full address is forwarded.
- R13: `irq` is high while CSR bit 1 reads 1 and `irq_en` is high. It drops the cycle after the retire write that empties the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 4 | Host byte offset |
| host_wr_en | input | 1 | Host write strobe |
| host_rd_en | input | 1 | Host read strobe (drives the semaphore side effect) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for `host_addr` |
| sub_valid | output | 1 | Submit entry offered to the engine |
| sub_ready | input | 1 | Engine takes the submit entry |
| sub_addr | output | 32 | Descriptor address, upper byte masked in 24-bit mode |
| sub_amod | output | 8 | Address modifier of the entry |
| cmp_valid | input | 1 | Engine pushes a finished address |
| cmp_ready | output | 1 | Completion FIFO can take an entry |
| cmp_addr | input | 32 | Finished descriptor address |
| eng_busy | input | 1 | Engine busy indication |
| fatal_valid | input | 1 | Engine reports a fatal error |
| fatal_code | input | 8 | Fatal error code |
| eng_reset | output | 1 | Soft reset in progress |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Completion interrupt, level |

## Verification
The bench builds the block with MAX_OUT = 31, CMP_DEPTH = 4 and RESET_CYCLES = 20. These values put the descriptor limit, a full completion FIFO and the self-clearing end of a soft reset within a few hundred cycles. Random addresses and modifiers are driven through all 31 slots and compared with a bench model of the 24-bit masking. The 32nd add then shows that the limit holds the doorbell pending until a retire.

// File: rtl/desc_mbox_pkg.sv
package desc_mbox_pkg;
  // Register offsets: odd bytes only, the even bytes are unused filler
  localparam int OFF_ABYTE0 = 1;
  localparam int OFF_AMOD   = 9;
  localparam int OFF_CSR    = 11;
  localparam int OFF_FCODE  = 13;
  // CSR bit positions
  localparam int CSR_SEM    = 0;
  localparam int CSR_REM    = 1;
  localparam int CSR_ADD    = 2;
  localparam int CSR_SRST   = 3;
  localparam int CSR_MAINT  = 5;
  localparam int CSR_FATAL  = 6;
  localparam int CSR_BUSY   = 7;
  // Address modifier codes
  localparam logic [7:0] AMOD_A24 = 8'h3D;
  localparam logic [7:0] AMOD_A32 = 8'h0D;
endpackage

// File: rtl/mbox_cmp_fifo.sv
module mbox_cmp_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wptr_q, wptr_n, rptr_q, rptr_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign dout  = mem[rptr_q];

  always_comb begin
    wptr_n = wptr_q;
    rptr_n = rptr_q;
    cnt_n  = cnt_q;
    if (flush) begin
      wptr_n = '0;
      rptr_n = '0;
      cnt_n  = '0;
    end else begin
      if (push) wptr_n = bump(wptr_q);
      if (pop)  rptr_n = bump(rptr_q);
      if (push && !pop)      cnt_n = cnt_q + 1'b1;
      else if (pop && !push) cnt_n = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_n;
      rptr_q <= rptr_n;
      cnt_q  <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wptr_q] <= din;
  end

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/mbox_submit_slot.sv
module mbox_submit_slot
  import desc_mbox_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int MAX_OUT = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              add_req,
  input  logic [ADDR_W-1:0] stage_addr,
  input  logic [7:0]        stage_amod,
  input  logic              retire,
  input  logic              sub_ready,
  output logic              pending,
  output logic              sub_valid,
  output logic [ADDR_W-1:0] sub_addr,
  output logic [7:0]        sub_amod
);
  localparam int CNT_W = $clog2(MAX_OUT + 1);

  logic              full_q, full_n;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        amod_q;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              load, accept, at_limit, dec;

  assign at_limit  = (cnt_q >= CNT_W'(MAX_OUT));
  assign sub_valid = full_q && !at_limit && !flush;
  assign accept    = sub_valid && sub_ready;
  assign load      = add_req && !full_q && !flush;
  assign dec       = retire && (cnt_q != '0);
  assign pending   = full_q;
  assign sub_amod  = amod_q;
  assign sub_addr  = (amod_q == AMOD_A24) ? {8'h00, addr_q[ADDR_W-9:0]} : addr_q;

  always_comb begin
    full_n = full_q;
    cnt_n  = cnt_q;
    if (flush) begin
      full_n = 1'b0;
      cnt_n  = '0;
    end else begin
      if (load)        full_n = 1'b1;
      else if (accept) full_n = 1'b0;
      if (accept && !dec)      cnt_n = cnt_q + 1'b1;
      else if (dec && !accept) cnt_n = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      full_q <= full_n;
      cnt_q  <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      addr_q <= stage_addr;
      amod_q <= stage_amod;
    end
  end

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(MAX_OUT));
  assert_entry_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !accept && !flush) |=> ($stable(addr_q) && $stable(amod_q)));
  assert_load_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_q) |-> $past(add_req));
endmodule

// File: rtl/mbox_reset_seq.sv
module mbox_reset_seq #(
  parameter int CYCLES = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active
);
  localparam int CNT_W = $clog2(CYCLES + 1);

  logic             act_q, act_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  assign active = act_q;

  always_comb begin
    act_n = act_q;
    cnt_n = cnt_q;
    if (!act_q) begin
      if (start) begin
        act_n = 1'b1;
        cnt_n = '0;
      end
    end else begin
      cnt_n = cnt_q + 1'b1;
      if (cnt_q == CNT_W'(CYCLES - 1)) act_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act_n;
      cnt_q <= cnt_n;
    end
  end

  assert_reset_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (cnt_q < CNT_W'(CYCLES)));
endmodule

// File: rtl/desc_mbox_regs.sv
module desc_mbox_regs
  import desc_mbox_pkg::*;
#(
  parameter int HADDR_W      = 4,
  parameter int ADDR_W       = 32,
  parameter int MAX_OUT      = 31,
  parameter int CMP_DEPTH    = 4,
  parameter int RESET_CYCLES = 50_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HADDR_W-1:0] host_addr,
  input  logic              host_wr_en,
  input  logic              host_rd_en,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              sub_valid,
  input  logic              sub_ready,
  output logic [ADDR_W-1:0] sub_addr,
  output logic [7:0]        sub_amod,
  input  logic              cmp_valid,
  output logic              cmp_ready,
  input  logic [ADDR_W-1:0] cmp_addr,
  input  logic              eng_busy,
  input  logic              fatal_valid,
  input  logic [7:0]        fatal_code,
  output logic              eng_reset,
  input  logic              irq_en,
  output logic              irq
);
  localparam int NBYTES = ADDR_W / 8;

  logic [7:0]        stage_b [NBYTES];
  logic [ADDR_W-1:0] stage_addr, head_addr;
  logic [7:0]        amod_q;
  logic              maint_q, maint_n, sem_q, sem_n;
  logic              fatal_q, fatal_n;
  logic [7:0]        fcode_q, fcode_n;
  logic              csr_wr, csr_rd, flush, pending, cmp_empty, cmp_full;
  logic              rem_req, pop, push;

  assign csr_wr  = host_wr_en && (host_addr == HADDR_W'(OFF_CSR));
  assign csr_rd  = host_rd_en && (host_addr == HADDR_W'(OFF_CSR));
  assign rem_req = !cmp_empty;
  assign pop     = csr_wr && host_wdata[CSR_REM] && rem_req && !flush;
  assign cmp_ready = !cmp_full && !flush;
  assign push    = cmp_valid && cmp_ready;
  assign eng_reset = flush;
  assign irq     = rem_req && irq_en;

  // Address staging, one lane per byte at odd offsets
  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_b[b] <= '0;
      else if (host_wr_en && host_addr == HADDR_W'(OFF_ABYTE0 + 2 * b))
        stage_b[b] <= host_wdata;
    end
    assign stage_addr[8*b +: 8] = stage_b[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) amod_q <= '0;
    else if (host_wr_en && host_addr == HADDR_W'(OFF_AMOD)) amod_q <= host_wdata;
  end

  mbox_reset_seq #(.CYCLES(RESET_CYCLES)) u_rst (
    .clk(clk), .rst_n(rst_n),
    .start(csr_wr && host_wdata[CSR_SRST]),
    .active(flush)
  );

  mbox_submit_slot #(.ADDR_W(ADDR_W), .MAX_OUT(MAX_OUT)) u_slot (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .add_req(csr_wr && host_wdata[CSR_ADD]),
    .stage_addr(stage_addr), .stage_amod(amod_q),
    .retire(pop), .sub_ready(sub_ready), .pending(pending),
    .sub_valid(sub_valid), .sub_addr(sub_addr), .sub_amod(sub_amod)
  );

  mbox_cmp_fifo #(.W(ADDR_W), .DEPTH(CMP_DEPTH)) u_cmp (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(push), .din(cmp_addr), .pop(pop),
    .dout(head_addr), .empty(cmp_empty), .full(cmp_full)
  );

  always_comb begin
    maint_n = csr_wr ? host_wdata[CSR_MAINT] : maint_q;
    sem_n   = sem_q;
    if (csr_wr && host_wdata[CSR_SEM]) sem_n = 1'b0;
    else if (csr_rd)                   sem_n = 1'b1;
    fatal_n = fatal_q;
    fcode_n = fcode_q;
    if (flush) begin
      fatal_n = 1'b0;
      fcode_n = '0;
    end else if (fatal_valid && !fatal_q) begin
      fatal_n = 1'b1;
      fcode_n = fatal_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      maint_q <= 1'b0;
      sem_q   <= 1'b0;
      fatal_q <= 1'b0;
      fcode_q <= '0;
    end else begin
      maint_q <= maint_n;
      sem_q   <= sem_n;
      fatal_q <= fatal_n;
      fcode_q <= fcode_n;
    end
  end

  always_comb begin
    host_rdata = '0;
    for (int b = 0; b < NBYTES; b++) begin
      if (host_addr == HADDR_W'(OFF_ABYTE0 + 2 * b))
        host_rdata = rem_req ? head_addr[8*b +: 8] : stage_b[b];
    end
    if (host_addr == HADDR_W'(OFF_AMOD))  host_rdata = amod_q;
    if (host_addr == HADDR_W'(OFF_FCODE)) host_rdata = fcode_q;
    if (host_addr == HADDR_W'(OFF_CSR)) begin
      host_rdata[CSR_BUSY]  = eng_busy;
      host_rdata[CSR_FATAL] = fatal_q;
      host_rdata[CSR_MAINT] = maint_q;
      host_rdata[CSR_SRST]  = flush;
      host_rdata[CSR_ADD]   = pending;
      host_rdata[CSR_REM]   = rem_req;
      host_rdata[CSR_SEM]   = sem_q;
    end
  end

  assert_fatal_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fatal_q && !flush) |=> $stable(fcode_q));
  assert_sem_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rd && !csr_wr) |=> sem_q);
  assert_push_shows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !flush) |=> rem_req);
  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!pending && !fatal_q));
endmodule

// File: tb/desc_mbox_regs_tb.sv
module desc_mbox_regs_tb;
  localparam int MAXO = 31, CDEP = 4, RSTC = 20;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [3:0]  host_addr = '0;
  logic        host_wr_en = 1'b0, host_rd_en = 1'b0;
  logic [7:0]  host_wdata = '0, host_rdata;
  logic        sub_valid, sub_ready = 1'b0, cmp_ready, eng_reset, irq;
  logic [31:0] sub_addr, cmp_addr = '0;
  logic [7:0]  sub_amod, fatal_code = '0;
  logic        cmp_valid = 1'b0, eng_busy = 1'b0, fatal_valid = 1'b0, irq_en = 1'b0;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  desc_mbox_regs #(.MAX_OUT(MAXO), .CMP_DEPTH(CDEP), .RESET_CYCLES(RSTC)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr_en(host_wr_en),
    .host_rd_en(host_rd_en), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .sub_valid(sub_valid), .sub_ready(sub_ready), .sub_addr(sub_addr),
    .sub_amod(sub_amod), .cmp_valid(cmp_valid), .cmp_ready(cmp_ready),
    .cmp_addr(cmp_addr), .eng_busy(eng_busy), .fatal_valid(fatal_valid),
    .fatal_code(fatal_code), .eng_reset(eng_reset), .irq_en(irq_en), .irq(irq));

  function automatic logic [31:0] exp_fwd(input logic [31:0] a, input logic [7:0] m);
    return (m == 8'h3D) ? {8'h00, a[23:0]} : a;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr_en = 1'b1;
    @(negedge clk); host_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); host_addr = a; host_rd_en = 1'b1; #1 d = host_rdata;
    @(negedge clk); host_rd_en = 1'b0;
  endtask

  task automatic stage(input logic [31:0] a, input logic [7:0] m);
    for (int b = 0; b < 4; b++) wr(4'(2 * b + 1), a[8*b +: 8]);
    wr(4'd9, m);
  endtask

  task automatic take();
    @(negedge clk); sub_ready = 1'b1;
    @(negedge clk); sub_ready = 1'b0;
  endtask

  task automatic push(input logic [31:0] a, output bit ok);
    @(negedge clk); cmp_valid = 1'b1; cmp_addr = a; #1 ok = cmp_ready;
    @(negedge clk); cmp_valid = 1'b0;
  endtask

  task automatic rd_addr(output logic [31:0] a);
    logic [7:0] d;
    for (int b = 0; b < 4; b++) begin rd(4'(2 * b + 1), d); a[8*b +: 8] = d; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [31:0] a, ra;
    logic [7:0] m;
    bit ok;
    int unsigned seed;
    seed = $urandom(32'h5EED1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state and R10 semaphore
    rd(4'hB, d); check(d == 8'h00, "R10 reset csr", d, 8'h00);
    #1 check(!sub_valid && !irq && cmp_ready && !eng_reset, "R2 reset outputs", {sub_valid, irq, cmp_ready, eng_reset}, 4'b0010);
    rd(4'hD, d); check(d == 8'h00, "R7 fcode before error", d, 0);
    rd(4'hB, d); check(d[0], "R10 second reader sees 1", d[0], 1);
    wr(4'hB, 8'h01);
    rd(4'hB, d); check(!d[0], "R10 release", d[0], 0);

    // R1 decode
    stage(32'h12345678, 8'h0D);
    wr(4'h0, 8'hFF); wr(4'h2, 8'hEE);
    rd_addr(a); check(a == 32'h12345678, "R1 staged bytes", a, 32'h12345678);
    rd(4'h9, d); check(d == 8'h0D, "R1 amod", d, 8'h0D);
    rd(4'h2, d); check(d == 8'h00, "R1 even offset", d, 0);

    // R2 add, R3 ignored re-add
    wr(4'hB, 8'h04);
    #1 check(sub_valid && sub_addr == 32'h12345678 && sub_amod == 8'h0D, "R2 offer", sub_addr, 32'h12345678);
    rd(4'hB, d); check(d[2], "R2 pending", d[2], 1);
    stage(32'hAABBCCDD, 8'h3D);
    wr(4'hB, 8'h04);
    #1 check(sub_addr == 32'h12345678 && sub_amod == 8'h0D, "R3 entry held", sub_addr, 32'h12345678);
    take();
    rd(4'hB, d); check(!d[2], "R2 cleared after accept", d[2], 0);

    // R12 24-bit mode
    wr(4'hB, 8'h04);
    #1 check(sub_addr == 32'h00BBCCDD, "R12 upper byte forced", sub_addr, 32'h00BBCCDD);
    take();

    // R4, R5, R13 completions
    irq_en = 1'b1;
    push(32'h11112222, ok); push(32'h33334444, ok);
    rd(4'hB, d); check(d[1], "R4 remove request", d[1], 1);
    #1 check(irq, "R13 irq set", irq, 1);
    rd_addr(a); check(a == 32'h11112222, "R4 head address", a, 32'h11112222);
    wr(4'hB, 8'h02);
    rd_addr(a); check(a == 32'h33334444, "R5 next presented", a, 32'h33334444);
    #1 check(irq, "R13 irq held", irq, 1);
    wr(4'hB, 8'h02);
    #1 check(!irq, "R13 irq dropped", irq, 0);
    rd_addr(a); check(a == 32'hAABBCCDD, "R4 staged when empty", a, 32'hAABBCCDD);

    // R5 full FIFO
    for (int i = 0; i < CDEP; i++) push(32'h100 + i, ok);
    #1 check(!cmp_ready, "R5 full backpressure", cmp_ready, 0);
    for (int i = 0; i < CDEP; i++) begin
      rd_addr(a); check(a == 32'h100 + i, "R5 fifo order", a, 32'h100 + i);
      wr(4'hB, 8'h02);
    end

    // R11 and R12 random fill to the limit
    for (int i = 0; i < MAXO; i++) begin
      ra = $urandom();
      case ($urandom() % 3) 0: m = 8'h3D; 1: m = 8'h0D; default: m = 8'($urandom()); endcase
      stage(ra, m);
      wr(4'hB, 8'h04);
      #1 check(sub_valid && sub_addr == exp_fwd(ra, m) && sub_amod == m, "R12 random forward", sub_addr, exp_fwd(ra, m));
      take();
    end
    stage(32'hCAFEF00D, 8'h0D);
    wr(4'hB, 8'h04);
    repeat (3) @(negedge clk);
    #1 check(!sub_valid, "R11 limit blocks offer", sub_valid, 0);
    rd(4'hB, d); check(d[2], "R11 pending at limit", d[2], 1);
    push(32'h77, ok);
    wr(4'hB, 8'h02);
    #1 check(sub_valid && sub_addr == 32'hCAFEF00D, "R11 freed slot", sub_addr, 32'hCAFEF00D);
    take();
    rd(4'hB, d); check(!d[2], "R11 accepted after free", d[2], 0);

    // R7 fatal
    @(negedge clk); fatal_valid = 1'b1; fatal_code = 8'hF2;
    @(negedge clk); fatal_code = 8'hF0;
    @(negedge clk); fatal_valid = 1'b0;
    rd(4'hD, d); check(d == 8'hF2, "R7 first code held", d, 8'hF2);
    rd(4'hB, d); check(d[6], "R7 fatal bit", d[6], 1);

    // R6 busy
    eng_busy = 1'b1;
    rd(4'hB, d); check(d[7], "R6 busy reflects", d[7], 1);
    eng_busy = 1'b0;
    wr(4'hB, 8'h80);
    rd(4'hB, d); check(!d[7], "R6 write ignored", d[7], 0);

    // R9 maintenance
    wr(4'hB, 8'h20);
    rd(4'hB, d); check(d[5], "R9 maint set", d[5], 1);
    wr(4'hB, 8'h10);
    rd(4'hB, d); check(!d[4] && !d[5], "R9 bit4 zero, maint cleared", d, 0);

    // R8 soft reset
    push(32'h99, ok);
    stage(32'h0BADBEEF, 8'h0D);
    wr(4'hB, 8'h04);
    wr(4'hB, 8'h08);
    #1 check(eng_reset && !cmp_ready, "R8 reset active", {eng_reset, cmp_ready}, 2'b10);
    rd(4'hB, d); check((d & 8'h4E) == 8'h08, "R8 flushed csr", d & 8'h4E, 8'h08);
    rd(4'hD, d); check(d == 8'h00, "R8 fcode cleared", d, 0);
    wr(4'hB, 8'h00);
    rd(4'hB, d); check(d[3], "R8 write 0 does not abort", d[3], 1);
    repeat (RSTC + 2) @(negedge clk);
    rd(4'hB, d); check(!d[3], "R8 self clear", d[3], 0);
    #1 check(!eng_reset && cmp_ready, "R8 released", {eng_reset, cmp_ready}, 2'b01);
    wr(4'hB, 8'h04);
    #1 check(sub_valid && sub_addr == 32'h0BADBEEF, "R8 count zeroed", sub_addr, 32'h0BADBEEF);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule